// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time at a resolution of 1/256 second. A prescaler turns a 32768 Hz reference tick into a 256 Hz step that advances a chain of counters: a sub-second byte, then seconds, minutes, hours, a day-of-week value and a free-running 16-bit day count. Software gives the day count its meaning; at one step per day it spans roughly 179 years. A byte-wide register bus loads and reads every field. Reading the sub-second byte captures a snapshot of the wider fields, so a multi-byte read stays consistent while the clock keeps running.

An alarm unit compares the time against programmed sub-second, second, minute and hour values. Each of these fields has its own compare enable. With all four enabled, the alarm fires once per day at a set time. With only the low fields enabled, it fires periodically. A match sets a sticky flag, and the interrupt output is that flag gated by an enable bit. All state runs on the always-on clock `clk_i`, and `tick_i` acts only as an enable. The interrupt therefore does not depend on the processor clock and can wake a system whose core clock is stopped.

Register map (4-bit address): 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 day count low byte, 6 day count high byte, 8 alarm sub-second, 9 alarm seconds, 10 alarm minutes, 11 alarm hours, 12 alarm control, 13 status. Any unlisted address reads as zero.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every time field, every alarm register, the control register, the status flag and `alarm_irq_o` are zero.
- R2: The sub-second count advances by one after every DIV (default 128) cycles in which `tick_i` is high, and holds while `tick_i` is low.
- R3: On a step, the sub-second count wraps from 255 to 0 and carries into seconds. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours.
- R4: When hours wrap from 23 to 0, day of week advances and wraps from 6 to 0, and the 16-bit day count increments, wrapping from 0xFFFF to 0.
- R5: A write to address 1–6 loads that field, clears the sub-second count and restarts the prescaler. A write to address 0 loads the sub-second count and restarts the prescaler.
- R6: Reading address 0 returns the live sub-second count and captures seconds, minutes, hours, day of week and day count. Reads of addresses 1–6 return the captured values until the next read of address 0.
- R7: In the cycle after a step, the status flag (address 13, bit 0) sets if at least one compare enable is on and every enabled field equals its alarm register. Fields that are not enabled are ignored. The compare enables are control bits 0 (sub-second), 1 (seconds), 2 (minutes) and 3 (hours). With no compare enabled, the flag never sets.
- R8: The flag stays set until a write to address 13 with bit 0 set. `alarm_irq_o` is the flag ANDed with control bit 4.
- R9: With only the sub-second compare enabled, the alarm repeats once every 256 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick enable (32768 Hz rate) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (used for snapshot capture) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The bench preloads values one step short of each wrap boundary and checks the carry chain. It covers a plain minute carry, a midnight rollover with day of week at 6 and the day count at 0xFFFF, and a midnight rollover from mid-range values. A wrong wrap constant or a missing carry would show up as a field reading 60, 24 or 7, or as a day count that fails to move. The bench confirms that a field write restarts the prescaler: a design that kept the old prescaler count would step early after the write. It also confirms that reads of the wider fields stay frozen across a second boundary until the sub-second byte is read again. Alarm tests check that a disabled but mismatching hour field does not block a match and that an enabled mismatching minute field does. They also check that the flag survives further time and that the interrupt gate tracks its enable. A periodic sub-second alarm must stay quiet for 255 steps and then fire on the 256th.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SUB_W = 8;
  localparam int DAY_W = 16;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [2:0]       dow;
    logic [4:0]       hour;
    logic [5:0]       min;
    logic [5:0]       sec;
    logic [SUB_W-1:0] sub;
  } rtc_time_t;

  localparam logic [3:0] A_SUB   = 4'd0;
  localparam logic [3:0] A_SEC   = 4'd1;
  localparam logic [3:0] A_MIN   = 4'd2;
  localparam logic [3:0] A_HOUR  = 4'd3;
  localparam logic [3:0] A_DOW   = 4'd4;
  localparam logic [3:0] A_DAYL  = 4'd5;
  localparam logic [3:0] A_DAYH  = 4'd6;
  localparam logic [3:0] A_ASUB  = 4'd8;
  localparam logic [3:0] A_ASEC  = 4'd9;
  localparam logic [3:0] A_AMIN  = 4'd10;
  localparam logic [3:0] A_AHOUR = 4'd11;
  localparam logic [3:0] A_CTRL  = 4'd12;
  localparam logic [3:0] A_STAT  = 4'd13;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 128,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic step_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign step_o = tick_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R2
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       ld_en_i,
  input  logic [3:0] ld_sel_i,
  input  logic [7:0] ld_data_i,
  output rtc_time_t  time_o
);
  rtc_time_t t_q;
  logic sub_wrap, sec_wrap, min_wrap, hour_wrap;

  assign sub_wrap  = &t_q.sub;
  assign sec_wrap  = sub_wrap && (t_q.sec == 6'd59);
  assign min_wrap  = sec_wrap && (t_q.min == 6'd59);
  assign hour_wrap = min_wrap && (t_q.hour == 5'd23);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
    end else if (ld_en_i) begin
      t_q.sub <= '0;
      case (ld_sel_i)
        A_SUB:  t_q.sub              <= ld_data_i;
        A_SEC:  t_q.sec              <= ld_data_i[5:0];
        A_MIN:  t_q.min              <= ld_data_i[5:0];
        A_HOUR: t_q.hour             <= ld_data_i[4:0];
        A_DOW:  t_q.dow              <= ld_data_i[2:0];
        A_DAYL: t_q.day[7:0]         <= ld_data_i;
        A_DAYH: t_q.day[DAY_W-1:8]   <= ld_data_i;
        default: ;
      endcase
    end else if (step_i) begin
      t_q.sub <= t_q.sub + 1'b1;
      if (sub_wrap)  t_q.sec  <= (t_q.sec == 6'd59) ? 6'd0 : t_q.sec + 1'b1;
      if (sec_wrap)  t_q.min  <= (t_q.min == 6'd59) ? 6'd0 : t_q.min + 1'b1;
      if (min_wrap)  t_q.hour <= (t_q.hour == 5'd23) ? 5'd0 : t_q.hour + 1'b1;
      if (hour_wrap) begin
        t_q.dow <= (t_q.dow == 3'd6) ? 3'd0 : t_q.dow + 1'b1;
        t_q.day <= t_q.day + 1'b1;
      end
    end
  end

  assign time_o = t_q;

  // R2
  sub_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_en_i) |=> (t_q.sub == $past(t_q.sub) + 1'b1));
  // R4
  day_roll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_en_i && hour_wrap) |=> (t_q.day == $past(t_q.day) + 1'b1) && (t_q.hour == 5'd0));
  // R3
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_en_i && !(step_i && sub_wrap)) |=> $stable(t_q.sec));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  rtc_time_t        now_i,
  input  logic [SUB_W-1:0] a_sub_i,
  input  logic [5:0]       a_sec_i,
  input  logic [5:0]       a_min_i,
  input  logic [4:0]       a_hour_i,
  input  logic [3:0]       cmp_en_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [3:0] hit;
  logic       match;

  assign hit[0] = !cmp_en_i[0] || (now_i.sub  == a_sub_i);
  assign hit[1] = !cmp_en_i[1] || (now_i.sec  == a_sec_i);
  assign hit[2] = !cmp_en_i[2] || (now_i.min  == a_min_i);
  assign hit[3] = !cmp_en_i[3] || (now_i.hour == a_hour_i);
  assign match  = (|cmp_en_i) && (&hit);

  // a new match wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_o <= 1'b0;
    else if (eval_i && match)   flag_o <= 1'b1;
    else if (clr_i)             flag_o <= 1'b0;
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  // R7
  no_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && cmp_en_i == 4'd0) |=> !flag_o);
  // R7
  eval_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !eval_i) |=> !flag_o);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       alarm_irq_o
);
  rtc_time_t        now;
  rtc_time_t        snap_q;
  logic             step, eval_q, ld_en, flag, clr;
  logic [SUB_W-1:0] a_sub_q;
  logic [5:0]       a_sec_q, a_min_q;
  logic [4:0]       a_hour_q;
  logic [3:0]       cmp_en_q;
  logic             irq_en_q;

  assign ld_en = wr_en_i && (addr_i <= A_DAYH);
  assign clr   = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clr_i(ld_en), .step_o(step));

  rtc_timekeeper u_tk (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .ld_en_i(ld_en),
    .ld_sel_i(addr_i), .ld_data_i(wdata_i), .time_o(now));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_q   <= 1'b0;
      snap_q   <= '0;
      a_sub_q  <= '0;
      a_sec_q  <= '0;
      a_min_q  <= '0;
      a_hour_q <= '0;
      cmp_en_q <= '0;
      irq_en_q <= 1'b0;
    end else begin
      eval_q <= step && !ld_en;
      if (rd_en_i && addr_i == A_SUB) snap_q <= now;
      if (wr_en_i) begin
        case (addr_i)
          A_ASUB:  a_sub_q  <= wdata_i;
          A_ASEC:  a_sec_q  <= wdata_i[5:0];
          A_AMIN:  a_min_q  <= wdata_i[5:0];
          A_AHOUR: a_hour_q <= wdata_i[4:0];
          A_CTRL:  {irq_en_q, cmp_en_q} <= wdata_i[4:0];
          default: ;
        endcase
      end
    end
  end

  rtc_alarm u_alm (
    .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(eval_q), .now_i(now),
    .a_sub_i(a_sub_q), .a_sec_i(a_sec_q), .a_min_i(a_min_q), .a_hour_i(a_hour_q),
    .cmp_en_i(cmp_en_q), .clr_i(clr), .flag_o(flag));

  assign alarm_irq_o = flag && irq_en_q;

  always_comb begin
    case (addr_i)
      A_SUB:   rdata_o = now.sub;
      A_SEC:   rdata_o = {2'b0, snap_q.sec};
      A_MIN:   rdata_o = {2'b0, snap_q.min};
      A_HOUR:  rdata_o = {3'b0, snap_q.hour};
      A_DOW:   rdata_o = {5'b0, snap_q.dow};
      A_DAYL:  rdata_o = snap_q.day[7:0];
      A_DAYH:  rdata_o = snap_q.day[DAY_W-1:8];
      A_ASUB:  rdata_o = a_sub_q;
      A_ASEC:  rdata_o = {2'b0, a_sec_q};
      A_AMIN:  rdata_o = {2'b0, a_min_q};
      A_AHOUR: rdata_o = {3'b0, a_hour_q};
      A_CTRL:  rdata_o = {3'b0, irq_en_q, cmp_en_q};
      A_STAT:  rdata_o = {7'b0, flag};
      default: rdata_o = 8'h00;
    endcase
  end

  // R5
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i >= A_SEC && addr_i <= A_DAYH) |=> (now.sub == '0));
  // R6
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == A_SUB) |=> $stable(snap_q));
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> (rdata_o[0] || addr_i != A_STAT));
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_calendar uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .alarm_irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic run(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
    logic [7:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 14; a++) begin
      if (a == 0) rd_chk(4'(a), 0, "R1 sub");
      else if (a != 7) rd_chk(4'(a), 0, "R1 reg");
    end
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_step;
    run(127); rd_chk(0, 0, "R2 before step");
    run(1);   rd_chk(0, 1, "R2 after step");
    repeat (20) @(negedge clk);
    rd_chk(0, 1, "R2 hold without tick");
  endtask

  task automatic t_carry;
    wr(3, 10); wr(2, 59); wr(1, 59); wr(0, 255);
    run(128);
    rd_chk(0, 0, "R3 sub wrap");
    rd_chk(1, 0, "R3 sec wrap"); rd_chk(2, 0, "R3 min wrap"); rd_chk(3, 11, "R3 hour carry");
  endtask

  task automatic t_midnight(input int dow, input int day, input int edow, input int eday);
    wr(3, 23); wr(2, 59); wr(1, 59); wr(4, 8'(dow));
    wr(5, 8'(day)); wr(6, 8'(day >> 8)); wr(0, 255);
    run(128);
    rd_chk(0, 0, "R4 sub");
    rd_chk(3, 0, "R4 hour wrap"); rd_chk(4, edow, "R4 dow");
    rd_chk(5, eday & 8'hff, "R4 day lo"); rd_chk(6, eday >> 8, "R4 day hi");
  endtask

  task automatic t_load;
    wr(0, 8'h20); run(70);
    wr(1, 5);
    rd_chk(0, 0, "R5 sub cleared"); rd_chk(1, 5, "R5 sec loaded");
    run(100); rd_chk(0, 0, "R5 prescaler restarted");
    run(28);  rd_chk(0, 1, "R5 step after full period");
    wr(0, 8'h40); rd_chk(0, 8'h40, "R5 sub loaded");
  endtask

  task automatic t_snap;
    logic [7:0] v;
    wr(1, 7); wr(0, 255);
    rd(0, v);
    run(128);
    rd_chk(1, 7, "R6 snapshot frozen");
    rd(0, v); chk("R6 live sub", v, 0);
    rd_chk(1, 8, "R6 snapshot refreshed");
  endtask

  task automatic t_alarm;
    wr(3, 0); wr(2, 0); wr(1, 3); wr(0, 250);
    wr(8, 0); wr(9, 4); wr(11, 9);
    wr(12, 8'h13); wr(13, 1);
    run(5 * 128); @(negedge clk);
    rd_chk(13, 0, "R7 no early match");
    run(128); @(negedge clk);
    rd_chk(13, 1, "R7 match with hour disabled");
    chk("R8 irq asserted", irq, 1);
    run(300); rd_chk(13, 1, "R8 flag sticky");
    wr(12, 8'h03); chk("R8 irq gated off", irq, 0);
    wr(12, 8'h13); chk("R8 irq gated on", irq, 1);
    wr(13, 1); rd_chk(13, 0, "R8 flag cleared"); chk("R8 irq cleared", irq, 0);
    // enabled minute mismatch blocks the match
    wr(10, 5); wr(12, 8'h17);
    wr(2, 0); wr(1, 3); wr(0, 250);
    run(6 * 128); @(negedge clk);
    rd_chk(13, 0, "R7 enabled mismatch blocks");
    wr(12, 8'h10); wr(0, 255);
    run(3 * 128); @(negedge clk);
    rd_chk(13, 0, "R7 no compare enabled");
  endtask

  task automatic t_periodic;
    wr(8, 8'h10); wr(12, 8'h11); wr(0, 8'h0e);
    run(2 * 128); @(negedge clk);
    rd_chk(13, 1, "R9 first hit");
    wr(13, 1);
    run(255 * 128); @(negedge clk);
    rd_chk(13, 0, "R9 quiet for 255 steps");
    run(128); @(negedge clk);
    rd_chk(13, 1, "R9 repeat hit");
    chk("R9 irq", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_step;
    t_carry;
    t_midnight(6, 16'hffff, 0, 0);
    t_midnight(2, 16'h1234, 3, 16'h1235);
    t_load;
    t_snap;
    t_alarm;
    t_periodic;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule